// File: doc/BRIEF.md
# Synchronous Trap Entry Unit

This block performs trap entry for a hart that runs in user, supervisor and machine privilege. When a synchronous exception request arrives with its 4-bit cause code, trap value and the address of the faulting instruction, the unit decides which privilege level services the trap. The decision uses the current privilege and the machine exception-delegation mask. In the same cycle it returns the handler address from that level's trap-vector base. On the clock edge where the request is valid, it commits the saved PC, the cause, the trap value, the shuffled status bits and the new privilege together.

The unit holds one bank of saved-PC, cause and trap-value registers for each handler level, plus one shared status word. Supervisor and machine fields live at fixed bit positions in that word. The unit also flags causes that the surrounding core treats as fatal, and rejects the two reserved cause codes without touching any state. Privilege is encoded as U=0, S=1, M=3.

Top module: `trap_entry_unit`

## Requirements
- R1: A taken trap is routed to S (`trap_to_s`=1) only when `cur_mode` is U (0) or S (1) and bit `exc_cause` of `medeleg` is 1; otherwise it goes to M. `trap_to_s` is 0 whenever no trap is taken.
- R2: In the request cycle, `trap_pc` equals the selected vector (`stvec` for S, `mtvec` for M) with bits 1:0 forced to zero. It is 0 when no trap is taken.
- R3: On the edge of a taken trap, the target bank's saved PC takes `exc_pc`, its cause takes `exc_cause` zero-extended (so the top interrupt bit is 0), and its trap value takes `exc_tval`. The other bank keeps its values.
- R4: On an S trap, status bit 5 takes the old bit 1, bit 1 is cleared, and bit 8 becomes 1 if the previous mode was S and 0 if it was U.
- R5: On an M trap, status bit 7 takes the old bit 3, bit 3 is cleared, and bits 12:11 take the previous mode.
- R6: `fatal` is 1 during a valid request whose cause is 0, 1, 2, 5, 6 or 7, and 0 otherwise.
- R7: On the edge of a taken trap, `mode_q` becomes 1 for an S trap and 3 for an M trap.
- R8: A valid request with cause 10 or 14 raises `bad_cause`, keeps `trap_taken` low and changes no register.
- R9: With `exc_valid` low, no register changes, and `trap_taken`, `fatal` and `bad_cause` are 0.
- R10: After reset, `mode_q` is 3, all saved PC, cause and trap-value registers are 0, and `status` equals STATUS_INIT (default 0x0000_000A_0004_000A).
- R11: Status bits other than 1, 3, 5, 7, 8, 11 and 12 are never altered by a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | Exception request present this cycle |
| exc_cause | input | 4 | Exception cause code |
| exc_tval | input | 64 | Trap value to record |
| exc_pc | input | 64 | Address of the trapping instruction |
| cur_mode | input | 2 | Privilege at the time of the exception |
| medeleg | input | 64 | Exception delegation mask, one bit per cause |
| stvec | input | 64 | Supervisor trap-vector base |
| mtvec | input | 64 | Machine trap-vector base |
| trap_taken | output | 1 | Request accepted as a trap |
| trap_to_s | output | 1 | Accepted trap is handled at S |
| trap_pc | output | 64 | Handler address |
| fatal | output | 1 | Cause is in the fatal set |
| bad_cause | output | 1 | Reserved cause requested |
| mode_q | output | 2 | Privilege register |
| status | output | 64 | Shared status word |
| s_epc | output | 64 | Supervisor saved PC |
| s_cause | output | 64 | Supervisor cause |
| s_tval | output | 64 | Supervisor trap value |
| m_epc | output | 64 | Machine saved PC |
| m_cause | output | 64 | Machine cause |
| m_tval | output | 64 | Machine trap value |

## Verification
The properties assume that `cur_mode` never carries the unused encoding 2 and that all inputs are stable while the request is sampled. The bench changes inputs only on falling edges and uses only the encodings 0, 1 and 3. It sweeps all sixteen cause codes against delegation masks in which only the indexed bit differs, so a wrong bit index changes the routing. Directed sequences then chain S and M traps from different modes, so each status shuffle starts from a value that a previous trap left behind.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int SIE_BIT  = 1;
  localparam int MIE_BIT  = 3;
  localparam int SPIE_BIT = 5;
  localparam int MPIE_BIT = 7;
  localparam int SPP_BIT  = 8;
  localparam int MPP_LO   = 11;
  localparam int MPP_HI   = 12;

  function automatic logic cause_is_reserved(input logic [3:0] c);
    return (c == 4'd10) || (c == 4'd14);
  endfunction

  function automatic logic cause_is_fatal(input logic [3:0] c);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd5, 4'd6, 4'd7: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic logic may_delegate(input logic [1:0] mode);
    return (mode == PRIV_U) || (mode == PRIV_S);
  endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 4
) (
  input  logic               valid,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [1:0]         cur_mode,
  input  logic [XLEN-1:0]    deleg,
  input  logic [XLEN-1:0]    s_base,
  input  logic [XLEN-1:0]    m_base,
  output logic               taken,
  output logic               to_s,
  output logic               reserved,
  output logic               is_fatal,
  output logic [XLEN-1:0]    handler_pc
);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};

  logic deleg_hit;

  assign deleg_hit  = deleg[cause];
  assign reserved   = valid && cause_is_reserved(cause);
  assign taken      = valid && !cause_is_reserved(cause);
  assign is_fatal   = valid && cause_is_fatal(cause);
  assign to_s       = taken && may_delegate(cur_mode) && deleg_hit;

  always_comb begin
    if (!taken)   handler_pc = '0;
    else if (to_s) handler_pc = s_base & ALIGN_MASK;
    else          handler_pc = m_base & ALIGN_MASK;
  end
endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
  import trap_entry_pkg::*;
#(
  parameter int              XLEN        = 64,
  parameter logic [XLEN-1:0] STATUS_INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            taken,
  input  logic            to_s,
  input  logic [1:0]      prev_mode,
  output logic [XLEN-1:0] status_q
);
  function automatic logic [XLEN-1:0] enter_s(input logic [XLEN-1:0] st,
                                               input logic [1:0] prev);
    logic [XLEN-1:0] r;
    r           = st;
    r[SPIE_BIT] = st[SIE_BIT];
    r[SIE_BIT]  = 1'b0;
    r[SPP_BIT]  = prev[0];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] enter_m(input logic [XLEN-1:0] st,
                                               input logic [1:0] prev);
    logic [XLEN-1:0] r;
    r                = st;
    r[MPIE_BIT]      = st[MIE_BIT];
    r[MIE_BIT]       = 1'b0;
    r[MPP_HI:MPP_LO] = prev;
    return r;
  endfunction

  logic [XLEN-1:0] status_d;

  always_comb begin
    status_d = status_q;
    if (taken) status_d = to_s ? enter_s(status_q, prev_mode)
                               : enter_m(status_q, prev_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= STATUS_INIT;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/trap_bank.sv
module trap_bank #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [XLEN-1:0]    pc_in,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [XLEN-1:0]    tval_in,
  output logic [XLEN-1:0]    epc_q,
  output logic [XLEN-1:0]    cause_q,
  output logic [XLEN-1:0]    tval_q
);
  localparam int PAD_W = XLEN - CAUSE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else if (we) begin
      epc_q   <= pc_in;
      cause_q <= {{PAD_W{1'b0}}, cause_in};
      tval_q  <= tval_in;
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int              XLEN        = 64,
  parameter int              CAUSE_W     = 4,
  parameter logic [XLEN-1:0] STATUS_INIT = 64'h0000_000A_0004_000A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [XLEN-1:0]    exc_tval,
  input  logic [XLEN-1:0]    exc_pc,
  input  logic [1:0]         cur_mode,
  input  logic [XLEN-1:0]    medeleg,
  input  logic [XLEN-1:0]    stvec,
  input  logic [XLEN-1:0]    mtvec,
  output logic               trap_taken,
  output logic               trap_to_s,
  output logic [XLEN-1:0]    trap_pc,
  output logic               fatal,
  output logic               bad_cause,
  output logic [1:0]         mode_q,
  output logic [XLEN-1:0]    status,
  output logic [XLEN-1:0]    s_epc,
  output logic [XLEN-1:0]    s_cause,
  output logic [XLEN-1:0]    s_tval,
  output logic [XLEN-1:0]    m_epc,
  output logic [XLEN-1:0]    m_cause,
  output logic [XLEN-1:0]    m_tval
);
  localparam int NLVL  = 2;
  localparam int LVL_S = 0;

  logic            bank_we   [NLVL];
  logic [XLEN-1:0] epc_arr   [NLVL];
  logic [XLEN-1:0] cause_arr [NLVL];
  logic [XLEN-1:0] tval_arr  [NLVL];

  trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
    .valid      (exc_valid),
    .cause      (exc_cause),
    .cur_mode   (cur_mode),
    .deleg      (medeleg),
    .s_base     (stvec),
    .m_base     (mtvec),
    .taken      (trap_taken),
    .to_s       (trap_to_s),
    .reserved   (bad_cause),
    .is_fatal   (fatal),
    .handler_pc (trap_pc)
  );

  trap_status_upd #(.XLEN(XLEN), .STATUS_INIT(STATUS_INIT)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .taken     (trap_taken),
    .to_s      (trap_to_s),
    .prev_mode (cur_mode),
    .status_q  (status)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_bank
    assign bank_we[g] = trap_taken && (trap_to_s == (g == LVL_S));
    trap_bank #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bank_we[g]),
      .pc_in    (exc_pc),
      .cause_in (exc_cause),
      .tval_in  (exc_tval),
      .epc_q    (epc_arr[g]),
      .cause_q  (cause_arr[g]),
      .tval_q   (tval_arr[g])
    );
  end

  assign s_epc   = epc_arr[LVL_S];
  assign s_cause = cause_arr[LVL_S];
  assign s_tval  = tval_arr[LVL_S];
  assign m_epc   = epc_arr[1-LVL_S];
  assign m_cause = cause_arr[1-LVL_S];
  assign m_tval  = tval_arr[1-LVL_S];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= PRIV_M;
    else if (trap_taken) mode_q <= trap_to_s ? PRIV_S : PRIV_M;
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic [XLEN-1:0]    exc_pc,
  input logic [1:0]         cur_mode,
  input logic [XLEN-1:0]    medeleg,
  input logic               trap_taken,
  input logic               trap_to_s,
  input logic [XLEN-1:0]    trap_pc,
  input logic               fatal,
  input logic               bad_cause,
  input logic [1:0]         mode_q,
  input logic [XLEN-1:0]    status,
  input logic [XLEN-1:0]    s_epc,
  input logic [XLEN-1:0]    m_epc
);
  AST_S_NEEDS_DELEG: assert property (@(posedge clk) disable iff (!rst_n)
    trap_to_s |-> (cur_mode != 2'd3) && medeleg[exc_cause]); // R1
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> trap_pc[1:0] == 2'b00); // R2
  AST_MEPC_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && !trap_to_s) |=> m_epc == $past(exc_pc)); // R3
  AST_SEPC_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_to_s |=> s_epc == $past(exc_pc)); // R3
  AST_S_SHUFFLE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_to_s |=> !status[1] && (status[5] == $past(status[1]))); // R4
  AST_M_SHUFFLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && !trap_to_s) |=> !status[3] && (status[7] == $past(status[3]))
                                   && (status[12:11] == $past(cur_mode))); // R5
  AST_FATAL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> exc_valid); // R6
  AST_MODE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> mode_q == ($past(trap_to_s) ? 2'd1 : 2'd3)); // R7
  AST_RSVD_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cause |-> !trap_taken); // R8
  AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cause |=> $stable(status) && $stable(mode_q) && $stable(m_epc) && $stable(s_epc)); // R8
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> $stable(status) && $stable(mode_q)); // R9
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exc_valid  (exc_valid),
  .exc_cause  (exc_cause),
  .exc_pc     (exc_pc),
  .cur_mode   (cur_mode),
  .medeleg    (medeleg),
  .trap_taken (trap_taken),
  .trap_to_s  (trap_to_s),
  .trap_pc    (trap_pc),
  .fatal      (fatal),
  .bad_cause  (bad_cause),
  .mode_q     (mode_q),
  .status     (status),
  .s_epc      (s_epc),
  .m_epc      (m_epc)
);

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid;
  logic [3:0]  exc_cause;
  logic [63:0] exc_tval, exc_pc, medeleg, stvec, mtvec;
  logic [1:0]  cur_mode;
  logic        trap_taken, trap_to_s, fatal, bad_cause;
  logic [63:0] trap_pc, status, s_epc, s_cause, s_tval, m_epc, m_cause, m_tval;
  logic [1:0]  mode_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  trap_entry_unit dut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_tval(exc_tval), .exc_pc(exc_pc), .cur_mode(cur_mode), .medeleg(medeleg),
    .stvec(stvec), .mtvec(mtvec), .trap_taken(trap_taken), .trap_to_s(trap_to_s),
    .trap_pc(trap_pc), .fatal(fatal), .bad_cause(bad_cause), .mode_q(mode_q),
    .status(status), .s_epc(s_epc), .s_cause(s_cause), .s_tval(s_tval),
    .m_epc(m_epc), .m_cause(m_cause), .m_tval(m_tval)
  );

  localparam logic [63:0] ST_INIT = 64'h0000_000A_0004_000A;
  localparam logic [63:0] SVEC    = 64'h0000_0000_8000_0103;
  localparam logic [63:0] MVEC    = 64'h0000_0000_8000_0202;

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] cause;
    logic       dbit;
    logic       exp_s;
    logic       exp_fatal;
    logic       exp_bad;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{2'd0, 4'd0,  1'b1, 1'b1, 1'b1, 1'b0},
    '{2'd0, 4'd1,  1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd1, 4'd2,  1'b1, 1'b1, 1'b1, 1'b0},
    '{2'd3, 4'd3,  1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd0, 4'd4,  1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd1, 4'd5,  1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd0, 4'd6,  1'b1, 1'b1, 1'b1, 1'b0},
    '{2'd1, 4'd7,  1'b1, 1'b1, 1'b1, 1'b0},
    '{2'd0, 4'd8,  1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd1, 4'd9,  1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 4'd10, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'd3, 4'd11, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd1, 4'd12, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd0, 4'd13, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 4'd14, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'd0, 4'd15, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; exc_valid = 1'b0; exc_cause = '0; exc_tval = '0; exc_pc = '0;
    cur_mode = 2'd0; medeleg = '0; stvec = SVEC; mtvec = MVEC;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic issue(input logic [1:0] md, input logic [3:0] c, input logic [63:0] dg,
                       input logic [63:0] pc, input logic [63:0] tv);
    @(negedge clk);
    exc_valid = 1'b1; cur_mode = md; exc_cause = c; medeleg = dg; exc_pc = pc; exc_tval = tv;
  endtask

  task automatic step();
    @(posedge clk); #1;
    exc_valid = 1'b0;
  endtask

  task automatic check_banks(input string req, input logic [63:0] se, input logic [63:0] sc,
                             input logic [63:0] st, input logic [63:0] me,
                             input logic [63:0] mc, input logic [63:0] mt);
    chk({req, " s_epc"}, s_epc, se);   chk({req, " s_cause"}, s_cause, sc);
    chk({req, " s_tval"}, s_tval, st); chk({req, " m_epc"}, m_epc, me);
    chk({req, " m_cause"}, m_cause, mc); chk({req, " m_tval"}, m_tval, mt);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [1:0] exp_mode;
    do_reset();
    #1;
    // R10 reset state
    chk("R10 mode", {62'd0, mode_q}, 64'd3);
    chk("R10 status", status, ST_INIT);
    check_banks("R10", 0, 0, 0, 0, 0, 0);

    // Table sweep: routing R1, vector R2, fatal R6, reserved R8, mode R7
    exp_mode = 2'd3;
    for (int i = 0; i < 16; i++) begin
      logic [63:0] dg;
      dg = VECS[i].dbit ? (64'd1 << VECS[i].cause) : ~(64'd1 << VECS[i].cause);
      issue(VECS[i].mode, VECS[i].cause, dg, 64'h1000 + 64'(i), 64'h0);
      #1;
      chk("R1 trap_to_s", {63'd0, trap_to_s}, {63'd0, VECS[i].exp_s});
      chk("R6 fatal", {63'd0, fatal}, {63'd0, VECS[i].exp_fatal});
      chk("R8 bad_cause", {63'd0, bad_cause}, {63'd0, VECS[i].exp_bad});
      chk("R8 trap_taken", {63'd0, trap_taken}, {63'd0, !VECS[i].exp_bad});
      chk("R2 trap_pc", trap_pc, VECS[i].exp_bad ? 64'd0 :
          (VECS[i].exp_s ? (SVEC & ~64'd3) : (MVEC & ~64'd3)));
      if (!VECS[i].exp_bad) exp_mode = VECS[i].exp_s ? 2'd1 : 2'd3;
      step();
      chk("R7 mode after table trap", {62'd0, mode_q}, {62'd0, exp_mode});
    end

    // Directed chain from a fresh reset
    do_reset();
    // S trap from U, load page fault: R3 R4 R7 R11
    issue(2'd0, 4'd13, 64'd1 << 13, 64'h8000_1000, 64'hDEAD_BEE0);
    #1;
    chk("R2 s vector", trap_pc, 64'h8000_0100);
    step();
    chk("R4 R11 status S from U", status, 64'h0000_000A_0004_0028);
    check_banks("R3 S trap", 64'h8000_1000, 64'd13, 64'hDEAD_BEE0, 0, 0, 0);
    chk("R7 mode S", {62'd0, mode_q}, 64'd1);

    // S trap from S, ecall from U code: SPIE gets 0, SPP=1 (R4)
    issue(2'd1, 4'd8, 64'h0000_0000_0000_0100, 64'h8000_2000, 64'h8000_2000);
    step();
    chk("R4 status S from S", status, 64'h0000_000A_0004_0108);
    check_banks("R3 second S", 64'h8000_2000, 64'd8, 64'h8000_2000, 0, 0, 0);

    // M trap from S, illegal instruction not delegated (R5 R3 R6)
    issue(2'd1, 4'd2, ~(64'd1 << 2), 64'h8000_3000, 64'h0000_0000_FFFF_FFFF);
    #1;
    chk("R6 fatal illegal", {63'd0, fatal}, 64'd1);
    chk("R2 m vector", trap_pc, 64'h8000_0200);
    step();
    chk("R5 R11 status M from S", status, 64'h0000_000A_0004_0980);
    check_banks("R3 M trap", 64'h8000_2000, 64'd8, 64'h8000_2000,
                64'h8000_3000, 64'd2, 64'h0000_0000_FFFF_FFFF);
    chk("R7 mode M", {62'd0, mode_q}, 64'd3);

    // M trap from M with all delegation bits set: no delegation (R1 R5)
    issue(2'd3, 4'd11, '1, 64'h8000_4000, 64'h8000_4000);
    #1;
    chk("R1 M never delegates", {63'd0, trap_to_s}, 64'd0);
    step();
    chk("R5 status M from M", status, 64'h0000_000A_0004_1900);
    chk("R3 m_cause ecall M", m_cause, 64'd11);

    // Reserved causes leave everything (R8)
    issue(2'd0, 4'd10, '1, 64'h9999_0000, 64'h1234);
    step();
    issue(2'd1, 4'd14, '1, 64'h9999_0004, 64'h5678);
    step();
    chk("R8 status frozen", status, 64'h0000_000A_0004_1900);
    chk("R8 mode frozen", {62'd0, mode_q}, 64'd3);
    check_banks("R8 banks frozen", 64'h8000_2000, 64'd8, 64'h8000_2000,
                64'h8000_4000, 64'd11, 64'h8000_4000);

    // Idle request line (R9)
    @(negedge clk);
    exc_valid = 1'b0; cur_mode = 2'd0; exc_cause = 4'd0; medeleg = '1;
    exc_pc = 64'hAAAA_0000; exc_tval = 64'hBBBB;
    #1;
    chk("R9 taken idle", {63'd0, trap_taken}, 64'd0);
    chk("R9 fatal idle", {63'd0, fatal}, 64'd0);
    chk("R9 trap_pc idle", trap_pc, 64'd0);
    @(posedge clk); #1;
    chk("R9 status idle", status, 64'h0000_000A_0004_1900);
    check_banks("R9 banks idle", 64'h8000_2000, 64'd8, 64'h8000_2000,
                64'h8000_4000, 64'd11, 64'h8000_4000);

    finish_run();
  end
endmodule